// File: doc/BRIEF.md
# Instruction-Fetch Huffman Decompressor

This block sits inline in the instruction fetch path, between a program memory that holds a Huffman-compressed image and the processor's fetch port. The image is produced offline by an encoder. The block only decodes it. It reads the compressed bitstream as consecutive 32-bit words, keeps the bits in a shift buffer, and walks the prefix code one bit per cycle against a canonical code description fixed at elaboration. Each codeword it resolves is one byte of the original program.

Each decoded byte is offered on a valid/ready port. While the processor holds ready low, the byte on offer stays put and the decode position stops moving. A word fetch that is already in flight is still absorbed into the buffer. A restart pulse carries a word address. It throws away everything buffered or being decoded and starts a fresh stream at that word. A bit pattern that matches no codeword within the maximum code length raises a sticky error. The error stops decoding until the next restart.

Top module: `ifetch_huff_dec`

## Requirements
- R1: After reset the block is idle. It makes no memory request, keeps `out_valid` low and keeps `dec_err` low until the first restart pulse.
- R2: After a restart to address A, the word requests go to A, A+1, A+2 and so on in order. At most one request is outstanding at a time. A new request is issued only while fewer than 16 bits are buffered.
- R3: Bits are consumed most significant bit first within each word, and words are consumed in address order. The fixed canonical code is: 0x00=`00`, 0x20=`01`, 0x41=`100`, 0x42=`101`, 0x10=`1100`, 0x11=`1101`, 0xFF=`111000`, 0x7E=`1110010000000000`.
- R4: The sequence of bytes delivered equals the original byte sequence. This holds when codewords straddle a word boundary and when they reach the 16-bit maximum length.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` stays unchanged. No byte is lost or repeated across stalls.
- R6: A restart empties the bit buffer, drops any byte on offer, discards the data of a word request still in flight, and clears `dec_err`. No byte of the earlier stream is delivered after the restart.
- R7: When 16 bits have been examined without matching a codeword, `dec_err` is set and stays set until restart or reset. No further byte is delivered while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | One-cycle pulse: flush and begin decoding at `restart_addr` |
| restart_addr | input | 16 | Word address where the new stream starts |
| mem_req | output | 1 | One-cycle read request to program memory |
| mem_addr | output | 16 | Word address of the request |
| mem_rvalid | input | 1 | Read data valid, one cycle, one per request |
| mem_rdata | input | 32 | Compressed word returned by memory |
| out_valid | output | 1 | Decoded byte available |
| out_ready | input | 1 | Processor accepts the byte |
| out_byte | output | 8 | Decoded program byte |
| dec_err | output | 1 | Sticky invalid-code flag |

## Verification
The bench aims at codewords that straddle a 32-bit word edge and at runs of maximum-length 16-bit codes. A buffer that misplaces refill bits, or that refills too late, would deliver wrong or shifted bytes there.

Irregular ready patterns combined with slow memory test the stall behaviour. A decoder that kept consuming bits during a stall would change the held byte or skip symbols.

A restart is issued mid-stream while a word read is likely still outstanding. Absorbing that stale word would corrupt the first bytes of the new stream.

An image with an impossible bit pattern tests the error path. A decoder without a length limit would hang silently, and one that failed to stop would keep emitting garbage after the error.

// File: rtl/huff_fetch_pkg.sv
// Package: shared constants and the fixed canonical code description.
// Assumes: codeword lengths never exceed MAX_LEN; symbols listed in
// canonical order (by length, then by code value).
package huff_fetch_pkg;

    localparam int unsigned MAX_LEN = 16;
    localparam int unsigned SYM_W   = 8;
    localparam int unsigned NUM_SYM = 8;
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

    // Number of codewords of each length.
    function automatic int unsigned len_count(input int unsigned l);
        case (l)
            2, 3, 4: return 2;
            6, 16:   return 1;
            default: return 0;
        endcase
    endfunction

    // Symbol at canonical position idx.
    function automatic logic [SYM_W-1:0] sym_at(input int unsigned idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h20;
            2:       return 8'h41;
            3:       return 8'h42;
            4:       return 8'h10;
            5:       return 8'h11;
            6:       return 8'hFF;
            7:       return 8'h7E;
            default: return 8'h00;
        endcase
    endfunction

    // First canonical code value of length l.
    function automatic int unsigned first_code(input int unsigned l);
        int unsigned f;
        f = 0;
        for (int unsigned i = 1; i < l; i++) begin
            f = (f + len_count(i)) << 1;
        end
        return f;
    endfunction

    // Index of the first symbol of length l in the symbol list.
    function automatic int unsigned sym_offset(input int unsigned l);
        int unsigned s;
        s = 0;
        for (int unsigned i = 1; i < l; i++) begin
            s = s + len_count(i);
        end
        return s;
    endfunction

endpackage

// File: rtl/huff_canon_table.sv
// Module: combinational canonical-code lookup.
// Given the bits collected so far (right-aligned) and their count, reports
// whether they form a complete codeword and, if so, the decoded symbol.
// Assumes: code bits above len are zero.
module huff_canon_table
    import huff_fetch_pkg::*;
#(
    parameter int unsigned CODE_LEN = MAX_LEN
) (
    input  logic [CODE_LEN-1:0]            code,
    input  logic [$clog2(CODE_LEN+1)-1:0]  len,
    output logic                           hit,
    output logic [SYM_W-1:0]               sym
);
    localparam int unsigned LW = $clog2(CODE_LEN + 1);

    logic [CODE_LEN-1:0] hit_vec;
    logic [SYM_W-1:0]    sym_vec [CODE_LEN];

    // One comparator per code length, constants folded at elaboration.
    for (genvar g = 1; g <= CODE_LEN; g++) begin : g_len
        localparam logic [CODE_LEN:0] FIRST = (CODE_LEN+1)'(first_code(g));
        localparam logic [CODE_LEN:0] CNT   = (CODE_LEN+1)'(len_count(g));
        localparam int unsigned       OFS   = sym_offset(g);
        logic [CODE_LEN:0] diff;
        assign diff = {1'b0, code} - FIRST;
        assign hit_vec[g-1] = (len == LW'(g)) && ({1'b0, code} >= FIRST) && (diff < CNT);
        assign sym_vec[g-1] = sym_at(OFS + 32'(diff));
    end

    // Select the symbol of the single matching length.
    always_comb begin
        hit = |hit_vec;
        sym = '0;
        for (int i = 0; i < CODE_LEN; i++) begin
            if (hit_vec[i]) sym = sym_vec[i];
        end
    end

endmodule

// File: rtl/huff_bitbuf.sv
// Module: word fetcher and left-aligned bit shift buffer.
// Requests the next memory word whenever fewer than LOW_MARK bits are held
// and no request is outstanding; appends returned words behind the bits
// still held. The head bit is always buf_q[BUF_W-1].
// Assumes: memory returns exactly one rvalid per request, in order;
// BUF_W >= LOW_MARK + WORD_W so a refill never overflows.
module huff_bitbuf #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned BUF_W    = 64,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned LOW_MARK = 16,
    localparam int unsigned CNT_W   = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [ADDR_W-1:0] restart_addr,
    input  logic              take,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              bit_avail,
    output logic              head_bit,
    output logic [CNT_W-1:0]  level
);
    logic [BUF_W-1:0]  buf_q, buf_d, shifted, fill;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_rem;
    logic [ADDR_W-1:0] next_addr_q, mem_addr_q;
    logic              pend_q, drop_q, run_q, mem_req_q;
    logic              accept, want_fetch;

    // Next buffer contents: consume one bit, then merge any accepted word.
    always_comb begin
        shifted    = take ? {buf_q[BUF_W-2:0], 1'b0} : buf_q;
        cnt_rem    = cnt_q - CNT_W'(take);
        fill       = {mem_rdata, {(BUF_W-WORD_W){1'b0}}} >> cnt_rem;
        accept     = mem_rvalid && pend_q && !drop_q;
        buf_d      = accept ? (shifted | fill) : shifted;
        cnt_d      = accept ? (cnt_rem + CNT_W'(WORD_W)) : cnt_rem;
        want_fetch = run_q && !pend_q && (cnt_q < CNT_W'(LOW_MARK));
    end

    // Buffer, fetch-address and outstanding-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q       <= '0;
            cnt_q       <= '0;
            next_addr_q <= '0;
            mem_addr_q  <= '0;
            mem_req_q   <= 1'b0;
            pend_q      <= 1'b0;
            drop_q      <= 1'b0;
            run_q       <= 1'b0;
        end else if (restart) begin
            buf_q       <= '0;
            cnt_q       <= '0;
            next_addr_q <= restart_addr;
            mem_req_q   <= 1'b0;
            run_q       <= 1'b1;
            pend_q      <= pend_q && !mem_rvalid;
            drop_q      <= pend_q && !mem_rvalid;
        end else begin
            buf_q     <= buf_d;
            cnt_q     <= cnt_d;
            mem_req_q <= want_fetch;
            if (want_fetch) begin
                pend_q      <= 1'b1;
                mem_addr_q  <= next_addr_q;
                next_addr_q <= next_addr_q + 1'b1;
            end else if (mem_rvalid) begin
                pend_q <= 1'b0;
                drop_q <= 1'b0;
            end
        end
    end

    assign mem_req   = mem_req_q;
    assign mem_addr  = mem_addr_q;
    assign bit_avail = (cnt_q != '0);
    assign head_bit  = buf_q[BUF_W-1];
    assign level     = cnt_q;

endmodule

// File: rtl/huff_sym_decode.sv
// Module: bit-serial canonical decoder with an output holding register.
// Examines one buffered bit per cycle; on a match presents the byte and
// restarts the code accumulator; after MAX_LEN bits without a match sets a
// sticky error and stops. Stalls while a held byte is not accepted.
// Assumes: head_bit is meaningful whenever bit_avail is high.
module huff_sym_decode
    import huff_fetch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             bit_avail,
    input  logic             head_bit,
    input  logic             out_ready,
    output logic             take,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_byte,
    output logic             dec_err
);
    logic [MAX_LEN-1:0] code_q, code_n;
    logic [LEN_W-1:0]   len_q, len_n;
    logic               valid_q, err_q, can_step, hit;
    logic [SYM_W-1:0]   byte_q, sym;

    // Decide whether a bit is consumed this cycle and form the new code.
    always_comb begin
        can_step = bit_avail && !err_q && !restart && (!valid_q || out_ready);
        code_n   = {code_q[MAX_LEN-2:0], head_bit};
        len_n    = len_q + 1'b1;
    end

    huff_canon_table #(.CODE_LEN(MAX_LEN)) u_table (
        .code (code_n),
        .len  (len_n),
        .hit  (hit),
        .sym  (sym)
    );

    // Accumulator, output holding register and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            len_q   <= '0;
            valid_q <= 1'b0;
            byte_q  <= '0;
            err_q   <= 1'b0;
        end else if (restart) begin
            code_q  <= '0;
            len_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (valid_q && out_ready) valid_q <= 1'b0;
            if (can_step) begin
                if (hit) begin
                    valid_q <= 1'b1;
                    byte_q  <= sym;
                    code_q  <= '0;
                    len_q   <= '0;
                end else if (len_n == LEN_W'(MAX_LEN)) begin
                    err_q  <= 1'b1;
                    code_q <= '0;
                    len_q  <= '0;
                end else begin
                    code_q <= code_n;
                    len_q  <= len_n;
                end
            end
        end
    end

    assign take      = can_step;
    assign out_valid = valid_q;
    assign out_byte  = byte_q;
    assign dec_err   = err_q;

endmodule

// File: rtl/ifetch_huff_dec.sv
// Module: top of the fetch-path decompressor.
// Connects the word fetcher / bit buffer to the serial canonical decoder.
// Assumes: a single-outstanding memory read port with in-order responses.
module ifetch_huff_dec
    import huff_fetch_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BUF_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [ADDR_W-1:0] restart_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SYM_W-1:0]  out_byte,
    output logic              dec_err
);
    localparam int unsigned CNT_W = $clog2(BUF_W + 1);

    logic             take, bit_avail, head_bit;
    logic [CNT_W-1:0] buf_level;

    huff_bitbuf #(
        .WORD_W   (WORD_W),
        .BUF_W    (BUF_W),
        .ADDR_W   (ADDR_W),
        .LOW_MARK (MAX_LEN)
    ) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .restart_addr (restart_addr),
        .take         (take),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .bit_avail    (bit_avail),
        .head_bit     (head_bit),
        .level        (buf_level)
    );

    huff_sym_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .bit_avail (bit_avail),
        .head_bit  (head_bit),
        .out_ready (out_ready),
        .take      (take),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .dec_err   (dec_err)
    );

endmodule

// File: rtl/ifetch_huff_dec_chk.sv
// Module: protocol checker bound to ifetch_huff_dec.
// Tracks outstanding reads and expected fetch addresses from the ports.
module ifetch_huff_dec_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned BUF_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic [ADDR_W-1:0] restart_addr,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_byte,
    input logic              dec_err,
    input logic [CNT_W-1:0]  buf_level
);
    logic              ck_pend, ck_started;
    logic [ADDR_W-1:0] ck_next;

    // Shadow of outstanding reads, first restart and next expected address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_pend    <= 1'b0;
            ck_started <= 1'b0;
            ck_next    <= '0;
        end else begin
            if (mem_req) ck_pend <= 1'b1;
            else if (mem_rvalid) ck_pend <= 1'b0;
            if (restart) begin
                ck_started <= 1'b1;
                ck_next    <= restart_addr;
            end else if (mem_req) begin
                ck_next <= mem_addr + 1'b1;
            end
        end
    end

    // R1: idle until the first restart
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_started |-> (!mem_req && !out_valid && !dec_err));

    // R2: one outstanding read at a time
    a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ck_pend);

    // R2: sequential addresses from the restart address
    a_r2_seq_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ck_started) |-> (mem_addr == ck_next));

    // R2: buffer never exceeds its capacity
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        buf_level <= CNT_W'(BUF_W));

    // R5: held byte is stable under back-pressure
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !restart) |=> (out_valid && $stable(out_byte)));

    // R6: restart empties the buffer and drops the held byte
    a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!out_valid && buf_level == '0 && !dec_err));

    // R7: error is sticky until restart
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_err && !restart) |=> dec_err);

    // R7: no new byte appears while in error
    a_r7_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_err && !out_valid && !restart) |=> !out_valid);

endmodule

bind ifetch_huff_dec ifetch_huff_dec_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .BUF_W  (BUF_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .restart_addr (restart_addr),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_byte     (out_byte),
    .dec_err      (dec_err),
    .buf_level    (buf_level)
);

// File: tb/ifetch_huff_dec_tb.sv
`timescale 1ns/1ps
module ifetch_huff_dec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic [15:0] restart_addr = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;
    logic        dec_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    ifetch_huff_dec u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .restart_addr (restart_addr),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_byte     (out_byte),
        .dec_err      (dec_err)
    );

    // Memory image, stimulus state and collected output.
    logic [31:0] img [0:63];
    bit          bq [$];
    logic [7:0]  exp_q [$];
    logic [7:0]  got [$];
    int          mem_lat = 1;
    int          ready_mode = 0;
    logic [7:0]  lfsr = 8'h5A;
    int          pend_cnt = 0;
    logic [15:0] pend_addr = '0;
    logic [15:0] exp_addr = '0;
    int          req_count = 0;
    int          addr_fail = 0;
    int          hold_fail = 0;
    logic        prev_stall = 1'b0;
    logic [7:0]  prev_byte = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    // Monitor: memory model, ready pattern, address and hold checks, capture.
    always @(negedge clk) begin
        #1;
        mem_rvalid = 1'b0;
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = img[pend_addr[5:0]];
            end
        end
        if (mem_req) begin
            req_count++;
            if (mem_addr != exp_addr) addr_fail++;
            exp_addr  = mem_addr + 16'd1;
            pend_addr = mem_addr;
            pend_cnt  = mem_lat;
        end
        if (restart) exp_addr = restart_addr;
        if (prev_stall && !(out_valid && out_byte == prev_byte)) hold_fail++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = (ready_mode == 0) ? 1'b1 : (lfsr[1:0] != 2'b00 ? lfsr[2] : 1'b0);
        prev_stall = out_valid && !out_ready && !restart;
        prev_byte  = out_byte;
        if (out_valid && out_ready && !restart) got.push_back(out_byte);
    end

    task automatic put_code(input logic [15:0] c, input int n);
        for (int i = n - 1; i >= 0; i--) bq.push_back(c[i]);
    endtask

    // Encoder written from the R3 code table.
    task automatic put_sym(input logic [7:0] s);
        exp_q.push_back(s);
        case (s)
            8'h00: put_code(16'b00, 2);
            8'h20: put_code(16'b01, 2);
            8'h41: put_code(16'b100, 3);
            8'h42: put_code(16'b101, 3);
            8'h10: put_code(16'b1100, 4);
            8'h11: put_code(16'b1101, 4);
            8'hFF: put_code(16'b111000, 6);
            default: put_code(16'b1110010000000000, 16);
        endcase
    endtask

    task automatic pack(input int base);
        for (int w = 0; w * 32 < bq.size(); w++) begin
            logic [31:0] v;
            v = '0;
            for (int b = 0; b < 32; b++) begin
                if (w * 32 + b < bq.size()) v[31-b] = bq[w*32+b];
            end
            img[base+w] = v;
        end
        bq.delete();
    endtask

    task automatic clear_img();
        for (int i = 0; i < 64; i++) img[i] = '0;
        exp_q.delete();
        bq.delete();
    endtask

    task automatic start_at(input logic [15:0] a);
        @(negedge clk);
        restart = 1'b1;
        restart_addr = a;
        got.delete();
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic wait_bytes(input int n);
        for (int i = 0; i < 3000 && got.size() < n; i++) @(negedge clk);
    endtask

    task automatic compare(input string req, input int n);
        check(got.size() >= n, req, "byte count", got.size(), n);
        for (int i = 0; i < n && i < got.size(); i++)
            check(got[i] == exp_q[i], req, $sformatf("byte %0d", i), got[i], exp_q[i]);
    endtask

    // R1: reset state and idleness before the first restart.
    task automatic t_reset();
        repeat (10) @(negedge clk);
        check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        check(!dec_err, "R1", "dec_err after reset", dec_err, 0);
        check(req_count == 0, "R1", "requests before restart", req_count, 0);
    endtask

    // R3/R4: mixed code lengths with ready held high.
    task automatic t_basic();
        logic [7:0] seq [16] = '{8'h41, 8'h42, 8'h00, 8'h20, 8'h10, 8'h11, 8'hFF, 8'h7E,
                                 8'h20, 8'h41, 8'hFF, 8'h11, 8'h7E, 8'h00, 8'h42, 8'h10};
        clear_img();
        foreach (seq[i]) put_sym(seq[i]);
        pack(0);
        ready_mode = 0; mem_lat = 1;
        req_count = 0;
        start_at(16'd0);
        wait_bytes(16);
        compare("R3", 16);
        check(req_count > 0 && addr_fail == 0, "R2", "fetch address order", addr_fail, 0);
    endtask

    // R4/R2: long 16-bit codes crossing many word edges at a nonzero base.
    task automatic t_long();
        clear_img();
        for (int i = 0; i < 12; i++) put_sym(8'h7E);
        put_sym(8'h41);
        put_sym(8'hFF);
        pack(8);
        mem_lat = 2;
        start_at(16'd8);
        wait_bytes(14);
        compare("R4", 14);
        check(addr_fail == 0, "R2", "sequential addresses from 8", addr_fail, 0);
    endtask

    // R5: irregular back-pressure with slow memory.
    task automatic t_backpressure();
        clear_img();
        for (int i = 0; i < 40; i++) begin
            logic [2:0] k;
            k = 3'(i * 5 + i / 3);
            case (k)
                0: put_sym(8'h00); 1: put_sym(8'h20); 2: put_sym(8'h41); 3: put_sym(8'h42);
                4: put_sym(8'h10); 5: put_sym(8'h11); 6: put_sym(8'hFF); default: put_sym(8'h7E);
            endcase
        end
        pack(20);
        ready_mode = 1; mem_lat = 3;
        hold_fail = 0;
        start_at(16'd20);
        wait_bytes(40);
        compare("R5", 40);
        check(hold_fail == 0, "R5", "held byte changed during stall", hold_fail, 0);
        ready_mode = 0;
    endtask

    // R6: restart mid-stream with a read likely in flight.
    task automatic t_restart_mid();
        clear_img();
        for (int i = 0; i < 30; i++) put_sym(8'h7E);
        pack(0);
        exp_q.delete();
        for (int i = 0; i < 10; i++) put_sym((i % 2 == 0) ? 8'h11 : 8'h42);
        pack(40);
        mem_lat = 3; ready_mode = 1;
        start_at(16'd0);
        wait_bytes(3);
        start_at(16'd40);
        wait_bytes(10);
        compare("R6", 10);
        check(addr_fail == 0, "R6", "addresses after restart", addr_fail, 0);
        ready_mode = 0; mem_lat = 1;
    endtask

    // R7: invalid pattern sets a sticky error and silences output; restart clears.
    task automatic t_error();
        int n_before;
        clear_img();
        img[0] = {3'b100, 29'h1FFF_FFFF};
        img[1] = '1;
        start_at(16'd0);
        repeat (60) @(negedge clk);
        check(dec_err == 1'b1, "R7", "error raised", dec_err, 1);
        check(got.size() == 1 && got[0] == 8'h41, "R7", "bytes before error",
              got.size(), 1);
        n_before = got.size();
        repeat (30) @(negedge clk);
        check(dec_err == 1'b1, "R7", "error sticky", dec_err, 1);
        check(got.size() == n_before, "R7", "no output while in error", got.size(), n_before);
        clear_img();
        put_sym(8'h20); put_sym(8'h10);
        pack(0);
        start_at(16'd0);
        check(dec_err == 1'b0, "R6", "restart clears error", dec_err, 0);
        wait_bytes(2);
        compare("R7", 2);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) img[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_long();
        t_backpressure();
        t_restart_mid();
        t_error();
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule